// File: doc/BRIEF.md
# Burst Address Generator with Repeat Point

This block produces the address for one port of a banked memory. The address is a single counter, with a bank field on top and an in-bank offset below it. On every rising clock edge, three active-low commands choose one of four actions. The counter can take a new external address, step forward by one, keep its value, or jump back to the address most recently taken from outside.

Each external load is also stored in a repeat register, so the caller can re-run a burst from its starting point without supplying the address again. Increments carry out of the offset into the bank field. The highest address rolls over to zero. None of the commands depend on chip or lane enables, and none of them act between clock edges.

A repeat-valid flag clears on reset and sets on the first external load. Until that flag is set, the result of a repeat is undefined and must not be relied on.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is low, and after it is released with no command, the address is 0 and the repeat-valid flag is 0.
- R2: With repeatN high and loadN low at a rising edge, the address after that edge equals extAddr. The value of cntEnN does not matter.
- R3: Every load accepted under R2 overwrites the repeat register. A later repeat returns the most recent accepted load.
- R4: With repeatN low at a rising edge, the address becomes the repeat register value. loadN, cntEnN and extAddr are ignored, and the repeat register is left unchanged.
- R5: With repeatN high, loadN high and cntEnN low, the address increases by one at the edge.
- R6: With repeatN, loadN and cntEnN all high, the address holds and extAddr has no effect.
- R7: Incrementing from offset FFFh in bank k gives offset 0 in bank k+1. The offset is bits 11:0 and the bank is bits 17:12 of the address.
- R8: Incrementing from bank 63, offset FFFh, gives address 0.
- R9: The repeat-valid flag sets at the first accepted load and stays set until reset. A repeat never sets it.
- R10: bankOut always equals bits 17:12 of addrOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadN | input | 1 | Active-low external load command |
| cntEnN | input | 1 | Active-low increment command |
| repeatN | input | 1 | Active-low restore-to-last-load command |
| extAddr | input | 18 | External address presented for a load |
| addrOut | output | 18 | Current counter address |
| bankOut | output | 6 | Bank field of the current address |
| repeatValid | output | 1 | Set once the repeat register holds a loaded address |

## Verification
The bench builds the block with its default widths: a 6-bit bank field and a 12-bit offset. At these widths the offset carry into the bank field is reachable within a few steps, since loading FFEh sits two increments away from it. The full rollover from bank 63 is reachable the same way. The command-priority cases are driven with conflicting commands on the same edge. In these cases repeat is asserted together with load, and load together with increment. This shows that only the winning command changes the address or the repeat register.

// File: rtl/burst_addr_gen_pkg.sv
package burst_addr_gen_pkg;

  // One-hot strobes issued by the command decoder each cycle
  typedef struct packed {
    logic doRestore;
    logic doLoad;
    logic doIncr;
  } ctrlStrobes_t;

endpackage

// File: rtl/burst_addr_gen_ctrl.sv
module burst_addr_gen_ctrl
  import burst_addr_gen_pkg::*;
(
  input  logic         loadN,
  input  logic         cntEnN,
  input  logic         repeatN,
  output ctrlStrobes_t strobes
);

  // Priority: restore, then load, then increment; otherwise hold
  always_comb begin
    strobes = '0;
    if (!repeatN) begin
      strobes.doRestore = 1'b1;
    end else if (!loadN) begin
      strobes.doLoad = 1'b1;
    end else if (!cntEnN) begin
      strobes.doIncr = 1'b1;
    end
  end

endmodule

// File: rtl/burst_addr_gen_dp.sv
module burst_addr_gen_dp
  import burst_addr_gen_pkg::*;
#(
  parameter int BANK_W = 6,
  parameter int OFFS_W = 12,
  localparam int ADDR_W = BANK_W + OFFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] addrQ,
  output logic              validQ
);

  logic [ADDR_W-1:0] savedQ;
  logic [OFFS_W-1:0] offsNext;
  logic [BANK_W-1:0] bankNext;
  logic              offsCarry;
  logic [ADDR_W-1:0] incrAddr;
  logic [ADDR_W-1:0] addrD;

  // Offset increment; its carry steps the bank field, which rolls over
  assign {offsCarry, offsNext} = {1'b0, addrQ[OFFS_W-1:0]} + {{OFFS_W{1'b0}}, 1'b1};
  assign bankNext = addrQ[ADDR_W-1:OFFS_W] + {{(BANK_W-1){1'b0}}, offsCarry};
  assign incrAddr = {bankNext, offsNext};

  always_comb begin
    addrD = addrQ;
    if (strobes.doRestore)   addrD = savedQ;
    else if (strobes.doLoad) addrD = extAddr;
    else if (strobes.doIncr) addrD = incrAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      validQ <= 1'b0;
    end else begin
      addrQ <= addrD;
      if (strobes.doLoad) validQ <= 1'b1;
    end
  end

  // Repeat register: no reset, defined only after the first load
  always_ff @(posedge clk) begin
    if (strobes.doLoad) savedQ <= extAddr;
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_gen_pkg::*;
#(
  parameter int BANK_W = 6,
  parameter int OFFS_W = 12,
  localparam int ADDR_W = BANK_W + OFFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadN,
  input  logic              cntEnN,
  input  logic              repeatN,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] addrOut,
  output logic [BANK_W-1:0] bankOut,
  output logic              repeatValid
);

  ctrlStrobes_t strobes;

  burst_addr_gen_ctrl u_ctrl (
    .loadN  (loadN),
    .cntEnN (cntEnN),
    .repeatN(repeatN),
    .strobes(strobes)
  );

  burst_addr_gen_dp #(
    .BANK_W(BANK_W),
    .OFFS_W(OFFS_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .extAddr(extAddr),
    .addrQ  (addrOut),
    .validQ (repeatValid)
  );

  assign bankOut = addrOut[ADDR_W-1:OFFS_W];

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int BANK_W = 6,
  parameter int OFFS_W = 12,
  localparam int ADDR_W = BANK_W + OFFS_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadN,
  input logic              cntEnN,
  input logic              repeatN,
  input logic [ADDR_W-1:0] extAddr,
  input logic [ADDR_W-1:0] addrOut,
  input logic [BANK_W-1:0] bankOut,
  input logic              repeatValid
);

  // Independent record of the last accepted load, seen from the ports
  logic [ADDR_W-1:0] lastLoad;
  always_ff @(posedge clk) begin
    if (rstN && repeatN && !loadN) lastLoad <= extAddr;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (repeatN && !loadN) |=> addrOut == $past(extAddr));

  p_restore_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!repeatN && repeatValid) |=> addrOut == $past(lastLoad));

  p_incr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (repeatN && loadN && !cntEnN) |=> addrOut == ADDR_W'($past(addrOut) + 1'b1));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (repeatN && loadN && cntEnN) |=> $stable(addrOut));

  p_valid_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (repeatN && !loadN) |=> repeatValid);

  p_valid_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    repeatValid |=> repeatValid);

  p_valid_norepeat_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!repeatValid && !repeatN) |=> !repeatValid);

  p_reset_r1: assert property (@(posedge clk)
    !rstN |=> (addrOut == '0 && !repeatValid));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(
  .BANK_W(BANK_W),
  .OFFS_W(OFFS_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .loadN      (loadN),
  .cntEnN     (cntEnN),
  .repeatN    (repeatN),
  .extAddr    (extAddr),
  .addrOut    (addrOut),
  .bankOut    (bankOut),
  .repeatValid(repeatValid)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

  localparam int BANK_W = 6;
  localparam int OFFS_W = 12;
  localparam int ADDR_W = BANK_W + OFFS_W;
  localparam int NVEC   = 14;
  // Vector: {repeatN, loadN, cntEnN, extAddr, expAddr, expValid}
  localparam int VW     = 3 + 2 * ADDR_W + 1;

  localparam logic [VW-1:0] VEC [NVEC] = '{
    {3'b101, 18'h00FFE, 18'h00FFE, 1'b1}, // R2 load
    {3'b110, 18'h00000, 18'h00FFF, 1'b1}, // R5 incr
    {3'b110, 18'h00000, 18'h01000, 1'b1}, // R7 offset carry into bank
    {3'b111, 18'h2AAAA, 18'h01000, 1'b1}, // R6 hold ignores ext
    {3'b100, 18'h12345, 18'h12345, 1'b1}, // R2 load beats incr
    {3'b110, 18'h00000, 18'h12346, 1'b1}, // R5
    {3'b011, 18'h00000, 18'h12345, 1'b1}, // R3 repeat
    {3'b000, 18'h3FFFF, 18'h12345, 1'b1}, // R4 repeat beats load+incr
    {3'b110, 18'h00000, 18'h12346, 1'b1}, // R5
    {3'b011, 18'h00000, 18'h12345, 1'b1}, // R4 saved untouched
    {3'b101, 18'h3FFFE, 18'h3FFFE, 1'b1}, // R2
    {3'b110, 18'h00000, 18'h3FFFF, 1'b1}, // R5
    {3'b110, 18'h00000, 18'h00000, 1'b1}, // R8 full wrap
    {3'b011, 18'h00000, 18'h3FFFE, 1'b1}  // R3 latest load
  };

  function automatic string vecReq(int i);
    case (i)
      0, 4, 10: return "R2";
      1, 5, 8, 11: return "R5";
      2: return "R7";
      3: return "R6";
      6, 13: return "R3";
      7, 9: return "R4";
      default: return "R8";
    endcase
  endfunction

  logic              clk = 1'b0;
  logic              rstN;
  logic              loadN, cntEnN, repeatN;
  logic [ADDR_W-1:0] extAddr;
  logic [ADDR_W-1:0] addrOut;
  logic [BANK_W-1:0] bankOut;
  logic              repeatValid;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  burst_addr_gen #(.BANK_W(BANK_W), .OFFS_W(OFFS_W)) u_dut (
    .clk(clk), .rstN(rstN), .loadN(loadN), .cntEnN(cntEnN),
    .repeatN(repeatN), .extAddr(extAddr), .addrOut(addrOut),
    .bankOut(bankOut), .repeatValid(repeatValid)
  );

  task automatic check(string req, logic [ADDR_W-1:0] expA, logic expV);
    total++;
    if (addrOut !== expA || repeatValid !== expV) begin
      bad++;
      $display("FAIL %s addr=%h valid=%b expected addr=%h valid=%b",
               req, addrOut, repeatValid, expA, expV);
    end
    total++;
    if (bankOut !== expA[ADDR_W-1:OFFS_W]) begin
      bad++;
      $display("FAIL R10 bank=%h expected %h", bankOut, expA[ADDR_W-1:OFFS_W]);
    end
  endtask

  // Drive at falling edge, sample just after the next rising edge
  task automatic step(logic rN, logic lN, logic cN, logic [ADDR_W-1:0] a);
    @(negedge clk);
    repeatN = rN; loadN = lN; cntEnN = cN; extAddr = a;
    @(posedge clk);
    #1;
  endtask

  initial begin
    rstN = 1'b0; repeatN = 1'b1; loadN = 1'b1; cntEnN = 1'b1; extAddr = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", '0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    step(1'b1, 1'b1, 1'b1, '0);
    check("R1", '0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][VW-1], VEC[i][VW-2], VEC[i][VW-3], VEC[i][2*ADDR_W:ADDR_W+1]);
      check(vecReq(i), VEC[i][ADDR_W:1], VEC[i][0]);
    end

    // Mid-run reset clears address and flag
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); #1;
    check("R1", '0, 1'b0);
    @(negedge clk); rstN = 1'b1;

    // Repeat before any load must not set the valid flag
    step(1'b0, 1'b1, 1'b1, 18'h11111);
    total++;
    if (repeatValid !== 1'b0) begin
      bad++;
      $display("FAIL R9 valid=%b expected 0", repeatValid);
    end
    step(1'b1, 1'b0, 1'b1, 18'h00FFF);
    check("R9", 18'h00FFF, 1'b1);
    step(1'b1, 1'b1, 1'b0, '0);
    check("R7", 18'h01000, 1'b1);
    step(1'b1, 1'b1, 1'b1, '0);
    check("R9", 18'h01000, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule